// File: doc/BRIEF.md
# Fairness-Aware DRAM Request Selector

This block sits inside a DRAM controller that is shared by several hardware threads. Once per DRAM cycle it looks at every occupied slot of the request buffer and names one request to issue next. Each slot carries the following:

- the thread that owns it;
- its target bank and row;
- an age, where a larger value means older.

The block also reads the open row of every bank. From outside it receives a per-thread slowdown estimate in fixed point, where 16 stands for 1.0. The estimate is the shared stall time divided by the estimated stall time when the thread runs alone.

Each slowdown is multiplied by a thread weight that software programs. Larger weights raise a thread's weighted slowdown, so that thread is favoured. The block then compares the largest and the smallest weighted slowdown among threads that have a pending request against a programmable threshold.

- **Below the threshold:** the block uses a throughput order, row hits first and then the oldest request.
- **At or above the threshold:** the requests of the most slowed thread go first, then row hits, then the oldest.

A threshold near 1.0 enforces strict fairness. The reset value of about 16 practically disables the fairness order.

Top module: `fair_req_picker`

## Requirements
- R1: After reset, `grant_valid` and `fair_mode` are 0, every thread weight is 1 and the threshold is 0xFF.
- R2: When no `req_valid` bit is set, the next cycle shows `grant_valid` = 0.
- R3: The outputs are registered. A grant reflects the inputs at the previous rising edge and always names a slot whose valid bit was set.
- R4: In throughput order, a row hit beats a miss regardless of age. A request is a row hit when its row equals `bank_open_row` of its bank.
- R5: Among equal candidates the larger age wins, and equal ages go to the lower slot index.
- R6: The weighted slowdown of a thread is slowdown × weight. Only threads that own at least one valid request enter the maximum and minimum.
- R7: `fair_mode` is 1 exactly when 16 × max ≥ threshold × min, with the threshold in 4.4 fixed point. This is max/min ≥ threshold. With no valid request `fair_mode` is 0.
- R8: In fairness order, a request of the thread with the largest weighted slowdown wins first, with the lowest thread id winning a tie. The remaining order is the same as R4 and R5.
- R9: A write with `cfg_addr` < 4 sets that thread's weight to the low 4 bits of `cfg_wdata`. `cfg_addr` = 4 sets the 8-bit threshold. Addresses 5 to 7 change nothing.
- R10: When a single thread has pending requests the ratio is 1.0, so `fair_mode` is 1 exactly when the threshold ≤ 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 16 | Occupied buffer slots |
| req_thread | input | 32 | 2-bit owner thread per slot |
| req_bank | input | 32 | 2-bit bank per slot |
| req_row | input | 64 | 4-bit row per slot |
| req_age | input | 96 | 6-bit age per slot, larger is older |
| bank_open_row | input | 16 | 4-bit open row per bank |
| thr_slowdown | input | 32 | 8-bit slowdown per thread, 4.4 fixed point |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | 0-3 weight of thread, 4 threshold |
| cfg_wdata | input | 8 | Configuration write data |
| grant_valid | output | 1 | A request was chosen |
| grant_idx | output | 4 | Slot index of the chosen request |
| fair_mode | output | 1 | The fairness order was in force |

## Verification
Several internal faults show up at the ports one cycle after the inputs that expose them:

- A wrong weight or threshold register shows as a flipped `fair_mode`.
- A favourite thread chosen from threads without requests shows as a wrong `grant_idx`.
- A reversed row-hit or age priority also shows as a wrong `grant_idx`.

Directed vectors place each decision exactly on its boundary: ratio equal to the threshold, equal ages, and a single pending thread. Randomly weighted vectors then mix all priorities together.

// File: rtl/fair_req_picker.sv
module fair_req_picker #(
  parameter int NREQ  = 16,
  parameter int NTHR  = 4,
  parameter int NBANK = 4,
  parameter int ROWW  = 4,
  parameter int AGEW  = 6,
  parameter int SDW   = 8,
  parameter int WW    = 4,
  parameter int THW   = 8,
  parameter int FRAC  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NREQ-1:0]             req_valid,
  input  logic [NREQ*$clog2(NTHR)-1:0]  req_thread,
  input  logic [NREQ*$clog2(NBANK)-1:0] req_bank,
  input  logic [NREQ*ROWW-1:0]        req_row,
  input  logic [NREQ*AGEW-1:0]        req_age,
  input  logic [NBANK*ROWW-1:0]       bank_open_row,
  input  logic [NTHR*SDW-1:0]         thr_slowdown,
  input  logic                        cfg_we,
  input  logic [$clog2(NTHR+1)-1:0]   cfg_addr,
  input  logic [THW-1:0]              cfg_wdata,
  output logic                        grant_valid,
  output logic [$clog2(NREQ)-1:0]     grant_idx,
  output logic                        fair_mode
);
  localparam int IW  = $clog2(NREQ);
  localparam int TW  = $clog2(NTHR);
  localparam int BW  = $clog2(NBANK);
  localparam int WSW = SDW + WW;
  localparam int PW  = WSW + THW + 1;
  localparam int KW  = AGEW + 2;

  logic [WW-1:0]  weight [NTHR];
  logic [THW-1:0] thresh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NTHR; t++) weight[t] <= WW'(1);
      thresh <= '1;
    end else if (cfg_we) begin
      if (cfg_addr < (TW+1)'(NTHR)) weight[cfg_addr[TW-1:0]] <= cfg_wdata[WW-1:0];
      else if (cfg_addr == (TW+1)'(NTHR)) thresh <= cfg_wdata;
    end
  end

  logic [NTHR-1:0] pend;
  logic [WSW-1:0]  wsd [NTHR];
  logic [WSW-1:0]  smax, smin;
  logic [TW-1:0]   fav;
  logic            any_pend, fair;

  always_comb begin
    pend = '0;
    for (int i = 0; i < NREQ; i++)
      if (req_valid[i]) pend[req_thread[i*TW +: TW]] = 1'b1;
    smax = '0; smin = '1; fav = '0;
    for (int t = 0; t < NTHR; t++) begin
      wsd[t] = WSW'(thr_slowdown[t*SDW +: SDW]) * WSW'(weight[t]);
      if (pend[t]) begin
        if (wsd[t] > smax || smax == '0 && fav == '0 && !(|(pend & ((NTHR)'(1) << t) - 1'b1)))
          begin smax = wsd[t]; fav = TW'(t); end
        if (wsd[t] < smin) smin = wsd[t];
      end
    end
  end

  assign any_pend = |pend;
  assign fair = any_pend && ((PW'(smax) << FRAC) >= PW'(thresh) * PW'(smin));

  logic          found;
  logic [IW-1:0] win;
  logic [KW-1:0] best, key;

  always_comb begin
    found = 1'b0; win = '0; best = '0; key = '0;
    for (int i = 0; i < NREQ; i++) begin
      key = {fair && req_thread[i*TW +: TW] == fav,
             req_row[i*ROWW +: ROWW] == bank_open_row[req_bank[i*BW +: BW]*ROWW +: ROWW],
             req_age[i*AGEW +: AGEW]};
      if (req_valid[i] && (!found || key > best)) begin
        found = 1'b1; win = IW'(i); best = key;
      end
    end
  end

  logic [TW-1:0] fav_q, win_thr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_valid <= 1'b0; grant_idx <= '0; fair_mode <= 1'b0;
      fav_q <= '0; win_thr_q <= '0;
    end else begin
      grant_valid <= found; grant_idx <= win; fair_mode <= fair;
      fav_q <= fav; win_thr_q <= req_thread[win*TW +: TW];
    end
  end

  assert_grant_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (($past(req_valid) >> grant_idx) & NREQ'(1)) != '0);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(req_valid) == '0 |-> !grant_valid && !fair_mode);
  assert_thresh_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == (TW+1)'(NTHR) |=> thresh == $past(cfg_wdata));
  assert_fav_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && fair_mode |-> win_thr_q == fav_q);
endmodule

// File: tb/tb_fair_req_picker.sv
module tb_fair_req_picker;
  localparam int N = 16, T = 4, B = 4;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] req_valid;
  logic [N*2-1:0] req_thread, req_bank;
  logic [N*4-1:0] req_row;
  logic [N*6-1:0] req_age;
  logic [B*4-1:0] bank_open_row;
  logic [T*8-1:0] thr_slowdown;
  logic cfg_we;
  logic [2:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic grant_valid, fair_mode;
  logic [3:0] grant_idx;
  int vectors = 0, fails = 0;
  int m_w [T];
  int m_th;

  fair_req_picker dut (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_req(int i, int thr, int bank, int row, int age);
    req_valid[i] = 1'b1;
    req_thread[i*2 +: 2] = 2'(thr); req_bank[i*2 +: 2] = 2'(bank);
    req_row[i*4 +: 4] = 4'(row); req_age[i*6 +: 6] = 6'(age);
  endtask

  task automatic clear();
    req_valid = '0; req_thread = '0; req_bank = '0; req_row = '0; req_age = '0;
  endtask

  task automatic cfg(int a, int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
    if (a < T) m_w[a] = d & 15; else if (a == T) m_th = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic void model(output int ev, output int ei, output int ef);
    int wsd [T];
    bit pend [T];
    int mx, mn, fv, best, k;
    bit anyp, hit;
    for (int t = 0; t < T; t++) begin
      pend[t] = 0;
      wsd[t] = int'(thr_slowdown[t*8 +: 8]) * m_w[t];
    end
    for (int i = 0; i < N; i++) if (req_valid[i]) pend[req_thread[i*2 +: 2]] = 1;
    anyp = 0; mx = -1; mn = 1 << 30; fv = 0;
    for (int t = 0; t < T; t++) if (pend[t]) begin
      anyp = 1;
      if (wsd[t] > mx) begin mx = wsd[t]; fv = t; end
      if (wsd[t] < mn) mn = wsd[t];
    end
    ef = (anyp && mx * 16 >= m_th * mn) ? 1 : 0;
    ev = 0; ei = 0; best = -1;
    for (int i = 0; i < N; i++) if (req_valid[i]) begin
      hit = req_row[i*4 +: 4] == bank_open_row[req_bank[i*2 +: 2]*4 +: 4];
      k = req_age[i*6 +: 6] + (hit ? 64 : 0) +
          ((ef == 1 && req_thread[i*2 +: 2] == 2'(fv)) ? 128 : 0);
      if (k > best) begin best = k; ei = i; ev = 1; end
    end
  endfunction

  task automatic run(string req);
    int ev, ei, ef;
    @(posedge clk);
    @(negedge clk);
    model(ev, ei, ef);
    chk({req, " grant_valid"}, int'(grant_valid), ev);
    if (ev == 1) chk({req, " grant_idx"}, int'(grant_idx), ei);
    chk({req, " fair_mode"}, int'(fair_mode), ef);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int t = 0; t < T; t++) m_w[t] = 1;
    m_th = 255;
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    clear();
    bank_open_row = {4'd4, 4'd3, 4'd2, 4'd1};
    thr_slowdown = {4{8'd16}};
    repeat (3) @(negedge clk);
    chk("R1 grant_valid in reset", int'(grant_valid), 0);
    chk("R1 fair_mode in reset", int'(fair_mode), 0);
    rst_n = 1;
    run("R2 empty buffer");

    set_req(0, 0, 0, 3, 50); set_req(5, 1, 1, 2, 10);
    run("R4 hit beats older miss");

    clear();
    set_req(3, 0, 0, 9, 20); set_req(7, 1, 1, 9, 40); set_req(2, 2, 2, 9, 40);
    run("R5 oldest, tie to lower index");

    clear();
    cfg(T, 8'h18); cfg(1, 2);
    set_req(0, 0, 0, 1, 60); set_req(4, 1, 1, 9, 5); set_req(6, 1, 2, 9, 9);
    run("R8 favoured thread first");
    thr_slowdown[2*8 +: 8] = 8'd200;
    run("R6 idle thread excluded");
    cfg(1, 1);
    cfg(5, 8'h01);
    run("R9 write above threshold ignored");
    cfg(1, 3); thr_slowdown[1*8 +: 8] = 8'd8;
    run("R7 ratio equal to threshold");

    clear();
    set_req(9, 3, 3, 4, 1); set_req(11, 3, 0, 7, 30);
    cfg(T, 8'h10);
    run("R10 single thread, threshold 1.0");
    cfg(T, 8'h11);
    run("R10 single thread, threshold above 1.0");

    void'($urandom(32'd7));
    for (int v = 0; v < 300; v++) begin
      if (v % 25 == 0) begin
        for (int t = 0; t < T; t++) cfg(t, 1 + $urandom_range(0, 14));
        cfg(T, $urandom_range(16, 64));
      end
      clear();
      for (int i = 0; i < N; i++)
        if ($urandom_range(0, 2) == 0)
          set_req(i, $urandom_range(0, 3), $urandom_range(0, 3),
                  $urandom_range(0, 3), $urandom_range(0, 7));
      for (int b = 0; b < B; b++) bank_open_row[b*4 +: 4] = 4'($urandom_range(0, 3));
      for (int t = 0; t < T; t++) thr_slowdown[t*8 +: 8] = 8'($urandom_range(16, 63));
      run("R3 R4 R5 R7 R8 random");
    end
    finish_run();
  end
endmodule